// File: doc/BRIEF.md
# GPIO Bank with Grouped Interrupts

This block is a bank of general-purpose I/O lines behind a small word-addressed register interface. Software sets an output value and a direction per line. It can also invert the sense of each input and make a driven line flash at a fixed rate. Pad inputs are brought into the clock domain by a two-stage synchronizer. After that, an optional per-line inversion is applied, and the result is what software reads back as the input value.

The same inverted input value drives the interrupt logic. A line can raise an interrupt in two ways. The first is while its input value is high and its level mask bit is set. The second is after a low-to-high transition of its input value has been latched into a sticky cause register and its edge mask bit is set. Software clears cause bits by writing zeros to them. The per-line interrupt sources are OR-ed in groups of consecutive lines, and each group drives one registered summary interrupt output. A system interrupt controller typically takes these outputs and dispatches to a handler, which reads the cause and input registers to find the line.

Top module: `gpio_irq_bank`

## Requirements
- R1: The byte-addressed register map is output 0x00, direction 0x04, flash enable 0x08, input invert 0x0C, input value 0x10, edge cause 0x14, edge enable 0x18, level enable 0x1C. A read returns the addressed register on `bus_rdata` one cycle after `bus_rd`. For the input value register, that is the value present in the cycle of the request. An address above 0x1C, or one whose two low bits are not zero, reads 0, and a write to it changes nothing. Between reads, `bus_rdata` holds its last value.
- R2: A direction bit of 1 makes the line an input (`pad_oe` bit 0). A direction bit of 0 enables the driver (`pad_oe` bit 1), and the line is driven from the output register.
- R3: Reset is synchronous and active high. It clears the output, flash enable, input invert, edge cause, edge enable and level enable registers. It sets the direction register to all ones, so every line starts as an input.
- R4: Each input value bit is the pad level after two synchronizer flops, XOR-ed with the matching input invert bit. A pad change presented before clock edge t appears in a read issued in the cycle after edge t+1.
- R5: An edge cause bit is set one cycle after the matching input value bit is 1 while it was 0 in the previous cycle. With invert 0 this catches rising pad edges; with invert 1 it catches falling pad edges. A change of the invert bit that flips the input value from 0 to 1 also counts as such a transition.
- R6: A write to the edge cause register clears every bit written as 0 and keeps every bit written as 1. If a transition sets a bit in the same cycle that a write clears it, the bit ends up set.
- R7: Writes to the input value register have no effect.
- R8: The per-line source is (input value AND level enable) OR (edge cause AND edge enable). Summary output k is the OR of the sources of lines 8k to 8k+7, registered once.
- R9: For a driven line whose flash enable bit is set, `pad_out` shows the output bit ANDed with a square wave. The wave starts high after reset and inverts every `BLINK_HALF` cycles. With flash enable 0, `pad_out` equals the output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | NUM_LINES | Write data |
| bus_rdata | output | NUM_LINES | Read data, one cycle after the strobe |
| pad_in | input | NUM_LINES | Asynchronous pad levels |
| pad_out | output | NUM_LINES | Pad drive values |
| pad_oe | output | NUM_LINES | Pad driver enables |
| irq_group | output | NUM_LINES/GROUP_SIZE | Summary interrupt per line group |

## Verification
The bench builds the block with 32 lines and groups of eight, which gives four summary outputs. With that shape, a level source in one group and an edge source in another can both be seen on separate outputs. `BLINK_HALF` is reduced to 3 so that several complete flash periods fit into a short run, and the count of toggles over a fixed window is exact. The same build places the cause-set and the software clear on the same edge, and it checks that the invert bit moves the edge sensitivity from rising to falling pad transitions.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  // Word index (byte address bits 4:2) of each register.
  typedef enum logic [2:0] {
    SEL_OUT    = 3'd0,
    SEL_DIR    = 3'd1,
    SEL_FLASH  = 3'd2,
    SEL_INV    = 3'd3,
    SEL_VALUE  = 3'd4,
    SEL_CAUSE  = 3'd5,
    SEL_EMASK  = 3'd6,
    SEL_LMASK  = 3'd7
  } reg_sel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_edge_cause.sv
module gpio_edge_cause #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] value,
  input  logic             clr_we,
  input  logic [WIDTH-1:0] keep_bits,
  output logic [WIDTH-1:0] rise,
  output logic [WIDTH-1:0] cause
);
  logic [WIDTH-1:0] prev_q;
  logic [WIDTH-1:0] held;

  assign rise = value & ~prev_q;
  assign held = clr_we ? (cause & keep_bits) : cause;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      cause  <= '0;
    end else begin
      prev_q <= value;
      cause  <= held | rise;   // a new edge outranks a clear
    end
  end
endmodule

// File: rtl/gpio_irq_reduce.sv
module gpio_irq_reduce #(
  parameter int WIDTH      = 32,
  parameter int GROUP_SIZE = 8,
  localparam int NUM_GROUPS = WIDTH / GROUP_SIZE
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [WIDTH-1:0]      src,
  output logic [NUM_GROUPS-1:0] irq
);
  logic [NUM_GROUPS-1:0] grp_or;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    assign grp_or[g] = |src[g*GROUP_SIZE +: GROUP_SIZE];
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= '0;
    else     irq <= grp_or;
  end
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_bank_pkg::*;
#(
  parameter int NUM_LINES  = 32,
  parameter int GROUP_SIZE = 8,
  parameter int ADDR_W     = 8,
  parameter int BLINK_HALF = 2500000,
  localparam int NUM_GROUPS = NUM_LINES / GROUP_SIZE
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [NUM_LINES-1:0]  bus_wdata,
  output logic [NUM_LINES-1:0]  bus_rdata,
  input  logic [NUM_LINES-1:0]  pad_in,
  output logic [NUM_LINES-1:0]  pad_out,
  output logic [NUM_LINES-1:0]  pad_oe,
  output logic [NUM_GROUPS-1:0] irq_group
);
  localparam int CNT_W = $clog2(BLINK_HALF + 1);

  logic [NUM_LINES-1:0] out_q, dir_q, flash_q, inv_q, emask_q, lmask_q;
  logic [NUM_LINES-1:0] pad_sync, value_w, rise_w, cause_w, src_w;
  logic [CNT_W-1:0]     flash_cnt;
  logic                 flash_phase;

  // Address decode: aligned words inside the eight-register window.
  reg_sel_e sel;
  logic     in_map;
  logic     wr_hit;
  assign sel    = reg_sel_e'(bus_addr[4:2]);
  assign in_map = (bus_addr[ADDR_W-1:5] == '0) && (bus_addr[1:0] == 2'b00);
  assign wr_hit = bus_wr && in_map;

  gpio_sync #(.WIDTH(NUM_LINES), .STAGES(2)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pad_in),
    .q   (pad_sync)
  );

  assign value_w = pad_sync ^ inv_q;

  gpio_edge_cause #(.WIDTH(NUM_LINES)) u_cause (
    .clk       (clk),
    .rst       (rst),
    .value     (value_w),
    .clr_we    (wr_hit && (sel == SEL_CAUSE)),
    .keep_bits (bus_wdata),
    .rise      (rise_w),
    .cause     (cause_w)
  );

  assign src_w = (value_w & lmask_q) | (cause_w & emask_q);

  gpio_irq_reduce #(.WIDTH(NUM_LINES), .GROUP_SIZE(GROUP_SIZE)) u_reduce (
    .clk (clk),
    .rst (rst),
    .src (src_w),
    .irq (irq_group)
  );

  // Control registers.
  always_ff @(posedge clk) begin
    if (rst) begin
      out_q   <= '0;
      dir_q   <= '1;
      flash_q <= '0;
      inv_q   <= '0;
      emask_q <= '0;
      lmask_q <= '0;
    end else if (wr_hit) begin
      case (sel)
        SEL_OUT:   out_q   <= bus_wdata;
        SEL_DIR:   dir_q   <= bus_wdata;
        SEL_FLASH: flash_q <= bus_wdata;
        SEL_INV:   inv_q   <= bus_wdata;
        SEL_EMASK: emask_q <= bus_wdata;
        SEL_LMASK: lmask_q <= bus_wdata;
        default:   ;   // value and cause handled elsewhere
      endcase
    end
  end

  // Registered read port.
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      if (!in_map) begin
        bus_rdata <= '0;
      end else begin
        case (sel)
          SEL_OUT:   bus_rdata <= out_q;
          SEL_DIR:   bus_rdata <= dir_q;
          SEL_FLASH: bus_rdata <= flash_q;
          SEL_INV:   bus_rdata <= inv_q;
          SEL_VALUE: bus_rdata <= value_w;
          SEL_CAUSE: bus_rdata <= cause_w;
          SEL_EMASK: bus_rdata <= emask_q;
          SEL_LMASK: bus_rdata <= lmask_q;
          default:   bus_rdata <= '0;
        endcase
      end
    end
  end

  // Flash square wave, high after reset.
  always_ff @(posedge clk) begin
    if (rst) begin
      flash_cnt   <= '0;
      flash_phase <= 1'b1;
    end else if (flash_cnt == CNT_W'(BLINK_HALF - 1)) begin
      flash_cnt   <= '0;
      flash_phase <= ~flash_phase;
    end else begin
      flash_cnt <= flash_cnt + 1'b1;
    end
  end

  assign pad_out = out_q & (~flash_q | {NUM_LINES{flash_phase}});
  assign pad_oe  = ~dir_q;
endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk #(
  parameter int NUM_LINES  = 32,
  parameter int NUM_GROUPS = 4,
  parameter int ADDR_W     = 8
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  bus_wr,
  input logic [ADDR_W-1:0]     bus_addr,
  input logic [NUM_LINES-1:0]  bus_wdata,
  input logic [NUM_LINES-1:0]  pad_oe,
  input logic [NUM_LINES-1:0]  rise,
  input logic [NUM_LINES-1:0]  cause,
  input logic [NUM_LINES-1:0]  emask,
  input logic [NUM_GROUPS-1:0] irq_group
);
  logic past_ok = 1'b0;
  always_ff @(posedge clk) past_ok <= 1'b1;

  logic wr_dir, wr_cause;
  assign wr_dir   = bus_wr && (bus_addr == ADDR_W'(8'h04));
  assign wr_cause = bus_wr && (bus_addr == ADDR_W'(8'h14));

  AST_RESET_ALL_INPUT: assert property (@(posedge clk)
    past_ok && $past(rst) |-> pad_oe == '0);   // R3

  AST_DIR_DRIVES_OE: assert property (@(posedge clk) disable iff (rst)
    past_ok && !$past(rst) && $past(wr_dir) |-> pad_oe == ~$past(bus_wdata));   // R2

  AST_EDGE_SETS_CAUSE: assert property (@(posedge clk) disable iff (rst)
    past_ok && !$past(rst) |-> ($past(rise) & ~cause) == '0);   // R6

  AST_NO_SPURIOUS_CAUSE: assert property (@(posedge clk) disable iff (rst)
    past_ok && !$past(rst) |-> (cause & ~$past(cause) & ~$past(rise)) == '0);   // R5

  AST_CAUSE_STICKY: assert property (@(posedge clk) disable iff (rst)
    past_ok && !$past(rst) && !$past(wr_cause) |-> ($past(cause) & ~cause) == '0);   // R6

  AST_EDGE_RAISES_IRQ: assert property (@(posedge clk) disable iff (rst)
    past_ok && !$past(rst) && (($past(cause) & $past(emask)) != '0) |-> irq_group != '0);   // R8
endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(
  .NUM_LINES (NUM_LINES),
  .NUM_GROUPS(NUM_GROUPS),
  .ADDR_W    (ADDR_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .pad_oe    (pad_oe),
  .rise      (rise_w),
  .cause     (cause_w),
  .emask     (emask_q),
  .irq_group (irq_group)
);

// File: tb/test_gpio_irq_bank.sv
module test_gpio_irq_bank;
  localparam int N  = 32;
  localparam int GS = 8;
  localparam int NG = N / GS;
  localparam int AW = 8;
  localparam int BH = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_wr = 1'b0, bus_rd = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [N-1:0]  bus_wdata = '0, pad_in = '0;
  logic [N-1:0]  bus_rdata, pad_out, pad_oe;
  logic [NG-1:0] irq_group;

  int checks = 0, errors = 0;
  bit started = 0, finished = 0;

  always #5 clk = ~clk;

  gpio_irq_bank #(.NUM_LINES(N), .GROUP_SIZE(GS), .ADDR_W(AW), .BLINK_HALF(BH)) i_gpio_irq_bank (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .irq_group(irq_group)
  );

  // ---------------- behavioural reference model ----------------
  logic [N-1:0]  m_out, m_dir, m_fl, m_inv, m_cause, m_em, m_lm, m_s1, m_s2, m_prev, m_rdata;
  logic [NG-1:0] m_irq;
  int            m_cnt;
  logic          m_ph;

  function automatic logic [N-1:0] model_read(input logic [AW-1:0] a, input logic [N-1:0] val);
    if (a > 8'h1C || a[1:0] != 2'b00) return '0;
    case (a)
      8'h00: return m_out;
      8'h04: return m_dir;
      8'h08: return m_fl;
      8'h0C: return m_inv;
      8'h10: return val;
      8'h14: return m_cause;
      8'h18: return m_em;
      default: return m_lm;
    endcase
  endfunction

  always @(posedge clk) begin
    logic [N-1:0]  val, rs, src, ncause;
    logic [NG-1:0] nirq;
    if (rst) begin
      m_out = '0; m_dir = '1; m_fl = '0; m_inv = '0; m_cause = '0; m_em = '0; m_lm = '0;
      m_s1 = '0; m_s2 = '0; m_prev = '0; m_rdata = '0; m_irq = '0; m_cnt = 0; m_ph = 1'b1;
      started = 1;
    end else begin
      val = m_s2 ^ m_inv;
      rs  = val & ~m_prev;
      src = (val & m_lm) | (m_cause & m_em);
      for (int g = 0; g < NG; g++) nirq[g] = |src[g*GS +: GS];
      ncause = ((bus_wr && bus_addr == 8'h14) ? (m_cause & bus_wdata) : m_cause) | rs;
      if (bus_rd) m_rdata = model_read(bus_addr, val);
      if (bus_wr) begin
        case (bus_addr)
          8'h00: m_out = bus_wdata;
          8'h04: m_dir = bus_wdata;
          8'h08: m_fl  = bus_wdata;
          8'h0C: m_inv = bus_wdata;
          8'h18: m_em  = bus_wdata;
          8'h1C: m_lm  = bus_wdata;
          default: ;
        endcase
      end
      m_cause = ncause;
      m_irq   = nirq;
      m_prev  = val;
      m_s2    = m_s1;
      m_s1    = pad_in;
      if (m_cnt == BH - 1) begin m_cnt = 0; m_ph = ~m_ph; end
      else m_cnt++;
    end
  end

  task automatic check_eq(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-clock comparison against the model.
  always @(negedge clk) begin
    if (started && !finished) begin
      check_eq("R1 rdata vs model", bus_rdata, m_rdata);
      check_eq("R2 pad_oe vs model", pad_oe, ~m_dir);
      check_eq("R9 pad_out vs model", pad_out, m_out & (~m_fl | {N{m_ph}}));
      check_eq("R8 irq vs model", N'(irq_group), N'(m_irq));
    end
  end

  // ---------------- stimulus tasks (start and end at a falling edge) ----------------
  task automatic bus_write(input logic [AW-1:0] a, input logic [N-1:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [AW-1:0] a, input logic [N-1:0] exp, input string tag);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    check_eq(tag, bus_rdata, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : watchdog
    #2000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    int toggles;
    logic last;
    idle(3);
    rst = 1'b0;
    idle(1);
    // R3 reset values
    check_eq("R3 pad_oe after reset", pad_oe, '0);
    bus_read(8'h00, 32'h0, "R3 output reset");
    bus_read(8'h04, 32'hFFFF_FFFF, "R3 direction reset");
    bus_read(8'h08, 32'h0, "R3 flash reset");
    bus_read(8'h0C, 32'h0, "R3 invert reset");
    bus_read(8'h14, 32'h0, "R3 cause reset");
    bus_read(8'h18, 32'h0, "R3 edge enable reset");
    bus_read(8'h1C, 32'h0, "R3 level enable reset");

    // R2 direction and output drive
    bus_write(8'h04, 32'hFFFF_0000);
    bus_write(8'h00, 32'h0000_A5A5);
    check_eq("R2 driver enables", pad_oe, 32'h0000_FFFF);
    check_eq("R2 driven values", pad_out & pad_oe, 32'h0000_A5A5);
    bus_read(8'h00, 32'h0000_A5A5, "R1 output readback");

    // R4 synchronised input with inversion
    pad_in = 32'h1234_0000;
    idle(2);
    bus_read(8'h10, 32'h1234_0000, "R4 input value");
    bus_write(8'h0C, 32'h00FF_0000);
    bus_read(8'h10, 32'h12CB_0000, "R4 inverted input value");

    // R5 edges: rising with invert 0, falling with invert 1
    pad_in = '0;
    bus_write(8'h0C, 32'h0);
    idle(4);
    bus_write(8'h14, 32'h0);
    bus_read(8'h14, 32'h0, "R6 cause cleared");
    pad_in = 32'h0000_0200;
    idle(3);
    bus_read(8'h14, 32'h0000_0200, "R5 rising pad edge");
    bus_write(8'h0C, 32'h0000_0400);
    idle(3);
    bus_write(8'h14, 32'h0);
    bus_read(8'h14, 32'h0, "R6 clear with no new edge");
    pad_in = 32'h0000_0600;
    idle(3);
    bus_read(8'h14, 32'h0, "R5 inverted line ignores rising pad");
    pad_in = 32'h0000_0200;
    idle(3);
    bus_read(8'h14, 32'h0000_0400, "R5 inverted line catches falling pad");

    // R6 write-one keeps, write-zero clears, set beats clear
    pad_in = 32'h0000_0208;
    idle(3);
    bus_read(8'h14, 32'h0000_0408, "R6 two cause bits");
    bus_write(8'h14, 32'h0000_0008);
    bus_read(8'h14, 32'h0000_0008, "R6 ones kept zeros cleared");
    pad_in = 32'h0000_0228;
    idle(2);
    bus_write(8'h14, 32'h0);
    bus_read(8'h14, 32'h0000_0020, "R6 same-cycle set wins");

    // R7 input value register is read-only
    bus_write(8'h10, 32'hFFFF_FFFF);
    bus_read(8'h10, 32'h0000_0628, "R7 input value unchanged by write");
    bus_read(8'h0C, 32'h0000_0400, "R7 invert unchanged");

    // R8 grouped interrupts
    bus_write(8'h1C, 32'h0000_1000);
    pad_in = 32'h0000_1228;
    idle(4);
    check_eq("R8 level source on group 1", N'(irq_group), 32'h2);
    bus_write(8'h18, 32'h0000_0020);
    idle(2);
    check_eq("R8 edge source adds group 0", N'(irq_group), 32'h3);
    bus_write(8'h14, 32'h0);
    idle(2);
    check_eq("R8 cleared edge drops group 0", N'(irq_group), 32'h2);

    // R1 unmapped and misaligned accesses
    bus_write(8'h20, 32'hFFFF_FFFF);
    bus_read(8'h20, 32'h0, "R1 unmapped read");
    bus_read(8'h01, 32'h0, "R1 misaligned read");
    bus_read(8'h00, 32'h0000_A5A5, "R1 unmapped write harmless");

    // R9 flash: exactly 6 toggles over 18 cycles with half period 3
    bus_write(8'h08, 32'h0000_0001);
    last = pad_out[0];
    toggles = 0;
    for (int i = 0; i < 18; i++) begin
      @(negedge clk);
      if (pad_out[0] != last) toggles++;
      last = pad_out[0];
    end
    check_eq("R9 flash toggle count", N'(toggles), 32'd6);
    check_eq("R9 flash leaves other lines", pad_out[15:1], 15'h52D2);

    idle(2);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule